// File: doc/BRIEF.md
# Serial Header Auto-Baud Detector

This block watches a receive line that has already been synchronised to the local clock. It looks for a synchronisation header made of a long low period (the break), a short high gap (the delimiter) and the sync character 0x55 framed as an ordinary character: start bit, eight data bits sent LSB first, no parity and one stop bit. From the header it derives the number of reference clocks per bit. The data character receiver, the fractional divider and any register access sit outside this block and use its outputs.

The break and the delimiter are timed in whole bit times of the period currently in use, which the block receives on `bit_ref`. The sync character is timed in raw clocks, from its first falling edge to its fifth and last falling edge. That span is eight bit times, so the new period is the count divided by eight and rounded. A break that is too long, or a sync character that overruns the saturating counter, ends the header with its own sticky error flag. While a header is in progress the block asks the local transmitter to hold off. In dormant operation it opens the receive path only for the one character that follows a complete header.

The controller has six states. WAIT_HI waits for the line to be seen high, which is the state after reset and after either error. IDLE waits for a low level. BREAK times the low period. DELIM times the high gap after a qualified break. SYNC counts clocks and falling edges of the sync character. STOP waits for the stop bit. The transitions are:
- WAIT_HI to IDLE when the line is high.
- IDLE to BREAK on a low level.
- BREAK to DELIM when the line rises after at least 11 bit times.
- BREAK to IDLE when the line rises earlier than that.
- BREAK to WAIT_HI when the break timeout is reached.
- DELIM to SYNC on a falling edge.
- DELIM to IDLE when the gap reaches 8 bit times.
- SYNC to STOP on the fifth falling edge.
- SYNC or STOP to WAIT_HI when the counter saturates.
- STOP to IDLE when the line rises.

Top module: `lin_autobaud`

## Requirements
- R1: After reset the outputs `brk_det`, `brk_to_err`, `sync_to_err`, `hdr_done` and `tx_inhibit` are 0 and `bit_period` is 0. A low level cannot start a break until the line has been seen high, so a line that is held low through reset and then released never sets `brk_det`.
- R2: A low period qualifies as a break only if it lasts at least 11 bit times, where one bit time is `bit_ref` clocks. A shorter low period returns to IDLE without setting `brk_det`. A qualified break sets `brk_det` when the line rises.
- R3: When the low period reaches 22 bit times, `brk_to_err` is set, `tx_inhibit` drops, and no header completes until the line has gone high again.
- R4: The measured count is the number of clocks from the first falling edge of the sync character to its fifth falling edge. When the header completes with `meas_en` high, `bit_period` becomes (count + 4) >> 3. `bit_period` changes only in the cycle that `hdr_done` is high.
- R5: When `meas_en` is low at header completion, the header still completes (`hdr_done` pulses) and `bit_period` keeps its previous value.
- R6: If the sync counter reaches 32767 before the header ends, `sync_to_err` is set, `tx_inhibit` drops, no header completes and `bit_period` is unchanged.
- R7: `hdr_done` is a pulse one cycle wide. It rises one clock after the line goes high in the stop bit that follows the fifth falling edge.
- R8: `tx_inhibit` is high from the first low cycle of a break candidate until the header completes or is abandoned, and low otherwise.
- R9: With `dormant` low, `rx_accept` is always 1. With `dormant` high, `rx_accept` is 0 until a header completes, then 1 until `char_done` is pulsed.
- R10: If the delimiter stays high for 8 bit times, the header is abandoned: `tx_inhibit` drops, no `hdr_done` follows, and `brk_det` stays set.
- R11: `brk_det`, `brk_to_err` and `sync_to_err` are sticky. They are cleared together when a new low level starts in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Synchronised receive line, idle high |
| bit_ref | input | PER_W (13) | Current bit period in clocks, used to time the break and delimiter (2 or more) |
| meas_en | input | 1 | Enables the update of the measured period |
| dormant | input | 1 | Gates reception to the character that follows a header |
| char_done | input | 1 | Pulse from the character receiver when a character has been taken |
| brk_det | output | 1 | Sticky flag: a qualified break was seen |
| bit_period | output | PER_W (13) | Measured bit period in clocks |
| brk_to_err | output | 1 | Sticky flag: the break exceeded its limit |
| sync_to_err | output | 1 | Sticky flag: the sync counter saturated |
| hdr_done | output | 1 | One-cycle pulse at the end of a valid header |
| tx_inhibit | output | 1 | Holds the transmitter off while a header is in progress |
| rx_accept | output | 1 | Permits the character receiver to deliver a character |

## Verification
If the edge count is wrong, the header completes on the wrong edge. That shows up as a `bit_period` that is off by a multiple of a quarter bit, visible in the cycle after the stop bit rises. If the bit timer or the state is wrong, `tx_inhibit` is held or dropped at the wrong point, or a break is accepted or rejected against the 11 and 22 bit limits. Both show within one bit time of the boundary. A wrong error path shows at once as a missing sticky flag while `tx_inhibit` stays high. The bench sweeps break lengths, delimiter lengths, bit periods and rounding offsets, and then drives each abandonment path on its own.

// File: rtl/lin_autobaud_pkg.sv
package lin_autobaud_pkg;
    typedef enum logic [2:0] {
        ST_WAIT_HI,
        ST_IDLE,
        ST_BREAK,
        ST_DELIM,
        ST_SYNC,
        ST_STOP
    } lab_state_e;
endpackage

// File: rtl/lab_bit_timer.sv
// Counts whole bit times of a programmable period; the start cycle counts as the first clock.
module lab_bit_timer #(
    parameter int PER_W = 13,
    parameter int BIT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic [BIT_W-1:0] bits
);
    localparam logic [BIT_W-1:0] BITS_TOP = '1;

    logic [PER_W-1:0] tmr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr  <= '0;
            bits <= '0;
        end else if (start) begin
            tmr  <= PER_W'(1);
            bits <= '0;
        end else if (run) begin
            if (tmr >= period - 1'b1) begin
                tmr <= '0;
                if (bits != BITS_TOP) begin
                    bits <= bits + 1'b1;
                end
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lab_sync_meter.sv
// Saturating clock counter plus falling-edge counter for the 0x55 sync character.
module lab_sync_meter #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic             rx_fall,
    output logic [CNT_W-1:0] meas,
    output logic             last_edge,
    output logic             sat
);
    // falling edges after the first one in a framed 0x55
    localparam int FALLS = 4;
    localparam int EDG_W = $clog2(FALLS + 1);

    logic [CNT_W-1:0] cnt;
    logic [EDG_W-1:0] edges;

    assign sat       = (cnt == {CNT_W{1'b1}});
    assign last_edge = run && rx_fall && (edges == EDG_W'(FALLS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            edges <= '0;
            meas  <= '0;
        end else if (start) begin
            cnt   <= CNT_W'(1);
            edges <= '0;
        end else if (run) begin
            if (!sat) begin
                cnt <= cnt + 1'b1;
            end
            if (rx_fall && edges != EDG_W'(FALLS)) begin
                edges <= edges + 1'b1;
            end
            if (last_edge) begin
                meas <= cnt;
            end
        end
    end
endmodule

// File: rtl/lin_autobaud.sv
module lin_autobaud
    import lin_autobaud_pkg::*;
#(
    parameter  int CNT_W   = 15,
    parameter  int BRK_MIN = 11,
    parameter  int BRK_MAX = 22,
    parameter  int DLM_MAX = 8,
    localparam int PER_W   = CNT_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_in,
    input  logic [PER_W-1:0] bit_ref,
    input  logic             meas_en,
    input  logic             dormant,
    input  logic             char_done,
    output logic             brk_det,
    output logic [PER_W-1:0] bit_period,
    output logic             brk_to_err,
    output logic             sync_to_err,
    output logic             hdr_done,
    output logic             tx_inhibit,
    output logic             rx_accept
);
    localparam int BIT_W = $clog2(((BRK_MAX > DLM_MAX) ? BRK_MAX : DLM_MAX) + 1);

    lab_state_e state, nxt;
    logic             rx_q;
    logic             rx_fall;
    logic [BIT_W-1:0] bits;
    logic             bt_start, bt_run;
    logic             sm_start, sm_run;
    logic [CNT_W-1:0] meas;
    logic             last_edge, sat;
    logic [CNT_W:0]   rnd_sum;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx_in;
    end
    assign rx_fall = rx_q && !rx_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_HI;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_HI: if (rx_in) nxt = ST_IDLE;
            ST_IDLE:    if (!rx_in) nxt = ST_BREAK;
            ST_BREAK: begin
                if (bits >= BIT_W'(BRK_MAX))      nxt = ST_WAIT_HI;
                else if (rx_in)                   nxt = (bits >= BIT_W'(BRK_MIN)) ? ST_DELIM : ST_IDLE;
            end
            ST_DELIM: begin
                if (!rx_in)                       nxt = ST_SYNC;
                else if (bits >= BIT_W'(DLM_MAX)) nxt = ST_IDLE;
            end
            ST_SYNC: begin
                if (sat)            nxt = ST_WAIT_HI;
                else if (last_edge) nxt = ST_STOP;
            end
            ST_STOP: begin
                if (sat)        nxt = ST_WAIT_HI;
                else if (rx_in) nxt = ST_IDLE;
            end
            default: nxt = ST_WAIT_HI;
        endcase
    end

    assign bt_start = (state != nxt) && (nxt == ST_BREAK || nxt == ST_DELIM);
    assign bt_run   = (state == ST_BREAK) || (state == ST_DELIM);
    assign sm_start = (state == ST_DELIM) && (nxt == ST_SYNC);
    assign sm_run   = (state == ST_SYNC) || (state == ST_STOP);

    lab_bit_timer #(.PER_W(PER_W), .BIT_W(BIT_W)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (bt_start),
        .run    (bt_run),
        .period (bit_ref),
        .bits   (bits)
    );

    lab_sync_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sm_start),
        .run       (sm_run),
        .rx_fall   (rx_fall),
        .meas      (meas),
        .last_edge (last_edge),
        .sat       (sat)
    );

    // eight bit times measured: divide by eight with rounding
    assign rnd_sum = {1'b0, meas} + (CNT_W + 1)'(4);

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_det     <= 1'b0;
            brk_to_err  <= 1'b0;
            sync_to_err <= 1'b0;
            hdr_done    <= 1'b0;
            bit_period  <= '0;
            armed       <= 1'b0;
        end else begin
            hdr_done <= (state == ST_STOP) && (nxt == ST_IDLE);
            if (state == ST_IDLE && nxt == ST_BREAK) begin
                brk_det     <= 1'b0;
                brk_to_err  <= 1'b0;
                sync_to_err <= 1'b0;
            end
            if (state == ST_BREAK && nxt == ST_DELIM)   brk_det    <= 1'b1;
            if (state == ST_BREAK && nxt == ST_WAIT_HI) brk_to_err <= 1'b1;
            if ((state == ST_SYNC || state == ST_STOP) && nxt == ST_WAIT_HI) begin
                sync_to_err <= 1'b1;
            end
            if (state == ST_STOP && nxt == ST_IDLE) begin
                armed <= 1'b1;
                if (meas_en) bit_period <= rnd_sum[CNT_W:3];
            end else if (char_done) begin
                armed <= 1'b0;
            end
        end
    end

    assign tx_inhibit = (state == ST_BREAK) || (state == ST_DELIM) ||
                        (state == ST_SYNC)  || (state == ST_STOP);
    assign rx_accept  = !dormant || armed;
endmodule

// File: rtl/lin_autobaud_chk.sv
module lin_autobaud_chk #(
    parameter int PER_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             meas_en,
    input logic             dormant,
    input logic             brk_det,
    input logic [PER_W-1:0] bit_period,
    input logic             brk_to_err,
    input logic             sync_to_err,
    input logic             hdr_done,
    input logic             tx_inhibit,
    input logic             rx_accept
);
    // R7
    hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |=> !hdr_done);

    // R8
    hdr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_done |-> !tx_inhibit);

    // R2
    brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_det) |-> tx_inhibit);

    // R3
    brk_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_to_err) |-> (!tx_inhibit && !hdr_done));

    // R6
    sync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_to_err) |-> (!tx_inhibit && !hdr_done));

    // R4
    period_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_period != $past(bit_period)) |-> hdr_done);

    // R5
    period_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_done && !$past(meas_en)) |-> $stable(bit_period));

    // R9
    accept_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dormant |-> rx_accept);
endmodule

bind lin_autobaud lin_autobaud_chk #(.PER_W(PER_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .meas_en     (meas_en),
    .dormant     (dormant),
    .brk_det     (brk_det),
    .bit_period  (bit_period),
    .brk_to_err  (brk_to_err),
    .sync_to_err (sync_to_err),
    .hdr_done    (hdr_done),
    .tx_inhibit  (tx_inhibit),
    .rx_accept   (rx_accept)
);

// File: tb/lin_autobaud_test.sv
`timescale 1ns/1ps
module lin_autobaud_test;
    localparam int PER_W = 13;
    localparam int P     = 16;
    localparam int NV    = 7;
    localparam int WDOG  = 150000;
    // vectors: break bits, delimiter bits, sync bit clocks, extra clocks, measure enable
    localparam int VB[NV] = '{13, 13, 12, 10, 14, 21, 11};
    localparam int VD[NV] = '{ 1,  2,  1,  1,  4,  1,  1};
    localparam int VQ[NV] = '{16, 20, 20, 20, 37, 100, 16};
    localparam int VX[NV] = '{ 0,  3,  4,  0,  0,  7,  0};
    localparam int VE[NV] = '{ 1,  1,  1,  1,  0,  1,  1};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rx_in = 1'b1;
    logic [PER_W-1:0] bit_ref = PER_W'(P);
    logic             meas_en = 1'b1;
    logic             dormant = 1'b0;
    logic             char_done = 1'b0;
    logic             brk_det, brk_to_err, sync_to_err, hdr_done, tx_inhibit, rx_accept;
    logic [PER_W-1:0] bit_period;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    lin_autobaud uut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .bit_ref(bit_ref),
        .meas_en(meas_en), .dormant(dormant), .char_done(char_done),
        .brk_det(brk_det), .bit_period(bit_period), .brk_to_err(brk_to_err),
        .sync_to_err(sync_to_err), .hdr_done(hdr_done), .tx_inhibit(tx_inhibit),
        .rx_accept(rx_accept)
    );

    always @(posedge clk) begin
        if (hdr_done) done_cnt <= done_cnt + 1;
        cycles <= cycles + 1;
        if (cycles == WDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: act %0d cycles exp below %0d", cycles, WDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: act %0d exp %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int n);
        rx_in = lvl;
        repeat (n) @(negedge clk);
    endtask

    // framed 0x55, LSB first; extra clocks stretch the gap before the last falling edge
    task automatic send_sync(input int q, input int ex);
        hold(1'b0, q); hold(1'b1, q); hold(1'b0, q); hold(1'b1, q);
        hold(1'b0, q); hold(1'b1, q); hold(1'b0, q); hold(1'b1, q + ex);
        hold(1'b0, q); hold(1'b1, 2 * P);
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rx_in = lvl;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    int exp_per;
    int d0;

    initial begin
        do_reset(1'b1);
        // R1 reset state
        chk("R1 brk_det", int'(brk_det), 0);
        chk("R1 bit_period", int'(bit_period), 0);
        chk("R1 errors", int'(brk_to_err) + int'(sync_to_err), 0);
        chk("R1 tx_inhibit", int'(tx_inhibit), 0);
        chk("R1 hdr_done", int'(hdr_done), 0);
        chk("R9 accept not dormant", int'(rx_accept), 1);
        hold(1'b1, 20);

        exp_per = 0;
        for (int v = 0; v < NV; v++) begin
            meas_en = VE[v][0];
            d0 = done_cnt;
            hold(1'b0, VB[v] * P);
            hold(1'b1, VD[v] * P);
            send_sync(VQ[v], VX[v]);
            if (VB[v] >= 11 && VE[v] != 0) exp_per = (8 * VQ[v] + VX[v] + 4) >> 3;
            chk($sformatf("R2 R7 header count v%0d", v), done_cnt - d0, (VB[v] >= 11) ? 1 : 0);
            chk($sformatf("R4 R5 period v%0d", v), int'(bit_period), exp_per);
            chk($sformatf("R2 brk_det v%0d", v), int'(brk_det), (VB[v] >= 11) ? 1 : 0);
            chk($sformatf("R8 inhibit after v%0d", v), int'(tx_inhibit), 0);
            hold(1'b1, 20);
        end
        meas_en = 1'b1;

        // R8 inhibit during header
        hold(1'b0, 13 * P);
        chk("R8 inhibit in break", int'(tx_inhibit), 1);
        hold(1'b1, P / 2);
        chk("R8 inhibit in delimiter", int'(tx_inhibit), 1);
        hold(1'b1, P / 2);
        send_sync(16, 0);
        chk("R8 inhibit released", int'(tx_inhibit), 0);
        hold(1'b1, 20);

        // R3 break timeout
        d0 = done_cnt;
        hold(1'b0, 25 * P);
        chk("R3 brk_to_err", int'(brk_to_err), 1);
        chk("R3 inhibit dropped", int'(tx_inhibit), 0);
        hold(1'b1, 20);
        chk("R3 no header", done_cnt - d0, 0);
        // R11 flags clear at next low
        hold(1'b0, P);
        chk("R11 brk_to_err cleared", int'(brk_to_err), 0);
        hold(1'b1, 20);

        // R10 delimiter too long
        d0 = done_cnt;
        hold(1'b0, 13 * P);
        hold(1'b1, 9 * P);
        chk("R10 inhibit dropped", int'(tx_inhibit), 0);
        chk("R10 brk_det kept", int'(brk_det), 1);
        chk("R10 no header", done_cnt - d0, 0);
        hold(1'b1, 20);

        // R6 sync timeout
        d0 = done_cnt;
        hold(1'b0, 13 * P);
        hold(1'b1, P);
        hold(1'b0, P);
        hold(1'b1, 33000);
        chk("R6 sync_to_err", int'(sync_to_err), 1);
        chk("R6 inhibit dropped", int'(tx_inhibit), 0);
        chk("R6 no header", done_cnt - d0, 0);
        chk("R6 period kept", int'(bit_period), exp_per);
        hold(1'b1, 20);

        // R1 line low through reset
        do_reset(1'b0);
        d0 = done_cnt;
        hold(1'b0, 15 * P);
        hold(1'b1, 4 * P);
        chk("R1 held low no break", int'(brk_det), 0);
        chk("R1 held low no header", done_cnt - d0, 0);
        hold(1'b1, 20);

        // R9 dormant gating
        dormant = 1'b1;
        @(negedge clk);
        chk("R9 dormant closed", int'(rx_accept), 0);
        hold(1'b0, 13 * P);
        hold(1'b1, P);
        send_sync(24, 0);
        chk("R9 dormant opened", int'(rx_accept), 1);
        chk("R4 period after dormant header", int'(bit_period), 24);
        char_done = 1'b1;
        @(negedge clk);
        char_done = 1'b0;
        @(negedge clk);
        chk("R9 closed after char", int'(rx_accept), 0);
        dormant = 1'b0;
        @(negedge clk);
        chk("R9 open again", int'(rx_accept), 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule